// File: doc/BRIEF.md
# Command/Indicate Change Interrupt Unit

This block watches two command/indicate (C/I) code channels. A framing stage upstream extracts both channels from a serial time-division bus once per frame. The block keeps the received codes in host-readable registers and flags every valid code change on a single interrupt line. A frame strobe marks the cycle in which fresh codes are present on the receive inputs.

Channel 0 accepts a new code only after it has seen the same value in two consecutive frames. Its register is backed by one extra buffer slot. If more changes arrive before the host reads, the host later sees the first change and then the most recent one, and the codes in between are lost. Channel 1 has no filter and no buffer. Its register always shows the latest code, taken from either the downstream or the upstream line. Its change flag has an enable of its own. One read of the channel-0 register returns both change flags and clears them. A mode input picks whether codes are compared on four or on six bits.

Top module: `cic_irq_unit`

## Requirements
- R1: After reset, address 0 reads 8'h00, address 1 reads 8'h00, address 2 reads 8'h01 (channel-1 enable set, downstream line selected), and `ci_irq` is low.
- R2: A channel-0 code is taken into the register only when the value on the channel-0 input at a frame strobe matches the value at the previous frame strobe and also differs from the most recently taken code. A value present for only one frame has no effect.
- R3: When `mode_wide` is 0, only bits 3:0 take part in the change comparisons of both channels, so a change in bits 5:4 alone sets no flag. When `mode_wide` is 1, all six bits are compared.
- R4: A read of address 0 returns the channel-1 flag in bit 7, the channel-0 flag in bit 6 and the channel-0 code in bits 5:0. The read clears both flags.
- R5: If a second channel-0 change is taken before the host reads, the next read returns the first code. In the cycle after that read, the channel-0 flag is set again and the register holds the newer code.
- R6: If several channel-0 changes are taken before a read, the first read returns the first code, the second read returns the last code, and the intermediate codes are never returned.
- R7: At every frame strobe, the channel-1 register (address 1, bits 5:0, upper bits 0) takes the code from the selected line. The channel-1 flag is set on the first frame in which that code differs from the stored one, with no repeat confirmation.
- R8: While the channel-1 enable (address 2, bit 0) is 0, channel-1 changes do not set the flag. A change that occurred while the enable was 0 is not reported after the enable returns to 1.
- R9: Address 2, bit 1, selects the channel-1 source: 0 takes the downstream input, 1 takes the upstream input.
- R10: `ci_irq` is high when the channel-0 flag or the enabled channel-1 flag is set, and it stays high until a read of address 0 clears those flags.
- R11: A write to address 2 stores bits 1:0, and a read of address 2 returns them in bits 1:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wide | input | 1 | 1: compare all six code bits; 0: compare bits 3:0 only |
| frame_stb | input | 1 | One-cycle strobe marking new codes on the receive inputs |
| c0_rx | input | 6 | Received channel-0 code |
| c1_rx_dn | input | 6 | Received channel-1 code, downstream line |
| c1_rx_up | input | 6 | Received channel-1 code, upstream line |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of `host_rd` |
| ci_irq | output | 1 | Code-change interrupt |

## Verification
The bench builds the block with its default six-bit code and eight-bit host data. At this size every one of the 64 channel-1 codes can be stepped through, with the expected flag worked out from the previous code. Sweeping 15 channel-0 codes covers both the single-frame rejection and the two-frame acceptance for each value. At this size, short directed sequences also reach the two-deep buffer cases: overflow, re-raise after a read, and discard of intermediate codes.

// File: rtl/cic_pkg.sv
package cic_pkg;
  parameter int CI_W      = 6;
  parameter int CI_NARROW = 4;

  typedef logic [CI_W-1:0] ci_code_t;

  // Mask of the bits that take part in a comparison for the given mode.
  function automatic ci_code_t ci_mask(input logic wide);
    ci_code_t m;
    for (int i = 0; i < CI_W; i++) m[i] = wide || (i < CI_NARROW);
    return m;
  endfunction

  // Two codes count as equal when they agree on every compared bit.
  function automatic logic ci_same(input ci_code_t a, input ci_code_t b, input logic wide);
    return ((a ^ b) & ci_mask(wide)) == '0;
  endfunction
endpackage

// File: rtl/cic_ch0_path.sv
module cic_ch0_path
  import cic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_stb,
  input  ci_code_t rx,
  input  logic     wide,
  input  logic     rd0,
  output ci_code_t cir0,
  output logic     flag,
  output logic     pend_v,
  output logic     accept
);
  ci_code_t prev_q, cir_q, pend_q;
  logic     flag_q, pend_v_q;

  ci_code_t latest, cir_e;
  logic     stable, flag_e, pend_v_e;

  // Filter: same value in two frames in a row, and different from the last taken code.
  assign latest   = pend_v_q ? pend_q : cir_q;
  assign stable   = ci_same(rx, prev_q, wide);
  assign accept   = frame_stb && stable && !ci_same(rx, latest, wide);

  // State as seen after a host read in this cycle.
  assign flag_e   = rd0 ? pend_v_q : flag_q;
  assign cir_e    = (rd0 && pend_v_q) ? pend_q : cir_q;
  assign pend_v_e = rd0 ? 1'b0 : pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      cir_q    <= '0;
      pend_q   <= '0;
      flag_q   <= 1'b0;
      pend_v_q <= 1'b0;
    end else begin
      if (frame_stb) prev_q <= rx;
      if (accept && flag_e) begin
        cir_q    <= cir_e;
        pend_q   <= rx;
        pend_v_q <= 1'b1;
        flag_q   <= 1'b1;
      end else if (accept) begin
        cir_q    <= rx;
        pend_v_q <= pend_v_e;
        flag_q   <= 1'b1;
      end else begin
        cir_q    <= cir_e;
        pend_v_q <= pend_v_e;
        flag_q   <= flag_e;
      end
    end
  end

  assign cir0   = cir_q;
  assign flag   = flag_q;
  assign pend_v = pend_v_q;
endmodule

// File: rtl/cic_ch1_path.sv
module cic_ch1_path
  import cic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_stb,
  input  ci_code_t rx_dn,
  input  ci_code_t rx_up,
  input  logic     sel_up,
  input  logic     wide,
  input  logic     en,
  input  logic     rd0,
  output ci_code_t cir1,
  output ci_code_t rx_sel,
  output logic     flag,
  output logic     change
);
  ci_code_t cir_q;
  logic     flag_q;

  assign rx_sel = sel_up ? rx_up : rx_dn;
  assign change = frame_stb && !ci_same(rx_sel, cir_q, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cir_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (frame_stb) cir_q <= rx_sel;
      if (change && en) flag_q <= 1'b1;
      else if (rd0)     flag_q <= 1'b0;
    end
  end

  assign cir1 = cir_q;
  assign flag = flag_q;
endmodule

// File: rtl/cic_host_if.sv
module cic_host_if
  import cic_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ci_code_t          cir0,
  input  logic              flag0,
  input  logic              flag1_vis,
  input  ci_code_t          cir1,
  output logic [DATA_W-1:0] rdata,
  output logic              en1,
  output logic              sel_up,
  output logic              rd0
);
  localparam int PAD_ST = DATA_W - CI_W - 2;
  localparam int PAD_C1 = DATA_W - CI_W;
  localparam int PAD_CF = DATA_W - 2;

  localparam logic [ADDR_W-1:0] A_ST0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_C1  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(2);

  logic en_q, sel_q;
  wire  unused_wdata = ^wdata[DATA_W-1:2];

  assign rd0 = rd && (addr == A_ST0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      sel_q <= 1'b0;
    end else if (wr && addr == A_CFG) begin
      en_q  <= wdata[0];
      sel_q <= wdata[1];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        A_ST0:   rdata = {{PAD_ST{1'b0}}, flag1_vis, flag0, cir0};
        A_C1:    rdata = {{PAD_C1{1'b0}}, cir1};
        A_CFG:   rdata = {{PAD_CF{1'b0}}, sel_q, en_q};
        default: rdata = '0;
      endcase
    end
  end

  assign en1    = en_q;
  assign sel_up = sel_q;
endmodule

// File: rtl/cic_irq_unit.sv
module cic_irq_unit
  import cic_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              frame_stb,
  input  logic [CI_W-1:0]   c0_rx,
  input  logic [CI_W-1:0]   c1_rx_dn,
  input  logic [CI_W-1:0]   c1_rx_up,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ci_irq
);
  ci_code_t cir0, cir1, c1_sel;
  logic     cic0, cic1, pend_v, ch0_take, ch1_chg;
  logic     en1, sel_up, rd0, cic1_vis;

  cic_ch0_path u_ch0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx(c0_rx), .wide(mode_wide),
    .rd0(rd0), .cir0(cir0), .flag(cic0), .pend_v(pend_v), .accept(ch0_take)
  );

  cic_ch1_path u_ch1 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_dn(c1_rx_dn), .rx_up(c1_rx_up),
    .sel_up(sel_up), .wide(mode_wide), .en(en1), .rd0(rd0), .cir1(cir1),
    .rx_sel(c1_sel), .flag(cic1), .change(ch1_chg)
  );

  assign cic1_vis = cic1 && en1;

  cic_host_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .cir0(cir0), .flag0(cic0), .flag1_vis(cic1_vis), .cir1(cir1),
    .rdata(host_rdata), .en1(en1), .sel_up(sel_up), .rd0(rd0)
  );

  assign ci_irq = cic0 || cic1_vis;
endmodule

// File: rtl/cic_irq_unit_chk.sv
module cic_irq_unit_chk
  import cic_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     frame_stb,
  input logic     host_wr,
  input logic     rd0,
  input logic     pend_v,
  input logic     cic0,
  input logic     cic1,
  input logic     en1,
  input logic     ci_irq,
  input ci_code_t cir0,
  input ci_code_t cir1,
  input ci_code_t c1_sel
);
  // R4: a read with nothing buffered and no new frame leaves both flags clear
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && !pend_v && !frame_stb |=> !cic0 && !cic1);

  // R5: a read with a buffered code raises the channel-0 flag again
  a_r5_reraise: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && pend_v |=> cic0);

  // R2: without a frame or a read the channel-0 state does not move
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0 && !frame_stb |=> $stable(cic0) && $stable(cir0));

  // R7: the channel-1 register takes the selected line's code at each frame
  a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> cir1 == $past(c1_sel));

  // R8: with the enable off a clear channel-1 flag stays clear
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en1 && !cic1 |=> !cic1);

  // R10: the interrupt holds until a status read or a configuration write
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ci_irq && !rd0 && !host_wr |=> ci_irq);
endmodule

bind cic_irq_unit cic_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .host_wr(host_wr), .rd0(rd0),
  .pend_v(pend_v), .cic0(cic0), .cic1(cic1), .en1(en1), .ci_irq(ci_irq),
  .cir0(cir0), .cir1(cir1), .c1_sel(c1_sel)
);

// File: tb/cic_irq_unit_bench.sv
module cic_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wide = 1'b1;
  logic       frame_stb = 1'b0;
  logic [5:0] c0_rx = '0, c1_rx_dn = '0, c1_rx_up = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ci_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cic_irq_unit u_cic_irq_unit (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .frame_stb(frame_stb),
    .c0_rx(c0_rx), .c1_rx_dn(c1_rx_dn), .c1_rx_up(c1_rx_up), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ci_irq(ci_irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic frame(input logic [5:0] c0, input logic [5:0] dn, input logic [5:0] up);
    @(negedge clk);
    c0_rx = c0; c1_rx_dn = dn; c1_rx_up = up; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [5:0] prev1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", ci_irq, 0);
    rd(2'd0, d); check("R1 addr0", d, 8'h00);
    rd(2'd1, d); check("R1 addr1", d, 8'h00);
    rd(2'd2, d); check("R1 addr2", d, 8'h01);

    // R2 sweep: one frame is ignored, the second identical frame is taken
    for (int v = 1; v < 16; v++) begin
      frame(6'(v), 6'h00, 6'h00);
      check("R2 single frame", ci_irq, 0);
      frame(6'(v), 6'h00, 6'h00);
      check("R2 two frames irq", ci_irq, 1);
      rd(2'd0, d); check("R4 status read", d, 8'h40 | v);
      check("R4 cleared", ci_irq, 0);
    end
    frame(6'h0F, 6'h00, 6'h00);
    check("R2 same code again", ci_irq, 0);

    // R3 narrow mode ignores bits 5:4 on both channels
    mode_wide = 1'b0;
    frame(6'h1F, 6'h30, 6'h00);
    frame(6'h1F, 6'h30, 6'h00);
    check("R3 narrow no flag", ci_irq, 0);
    rd(2'd0, d); check("R3 narrow code kept", d, 8'h0F);
    rd(2'd1, d); check("R3 R7 cir1 updated", d, 8'h30);
    mode_wide = 1'b1;
    frame(6'h1F, 6'h30, 6'h00);
    check("R3 wide flag", ci_irq, 1);
    rd(2'd0, d); check("R3 wide code", d, 8'h5F);

    // R5 second change before read
    frame(6'h21, 6'h30, 6'h00); frame(6'h21, 6'h30, 6'h00);
    frame(6'h22, 6'h30, 6'h00); frame(6'h22, 6'h30, 6'h00);
    rd(2'd0, d); check("R5 first code", d, 8'h61);
    check("R5 reraise", ci_irq, 1);
    rd(2'd0, d); check("R5 newer code", d, 8'h62);
    check("R5 cleared", ci_irq, 0);

    // R6 several changes: first and last only
    for (int v = 5; v <= 8; v++) begin
      frame(6'(v), 6'h30, 6'h00); frame(6'(v), 6'h30, 6'h00);
    end
    rd(2'd0, d); check("R6 first", d, 8'h45);
    rd(2'd0, d); check("R6 last", d, 8'h48);
    check("R6 drained irq", ci_irq, 0);
    rd(2'd0, d); check("R6 no flag", d, 8'h08);

    // R7 sweep over every channel-1 code
    prev1 = 6'h30;
    for (int v = 0; v < 64; v++) begin
      int e;
      frame(6'h08, 6'(v), 6'h00);
      e = (6'(v) != prev1) ? 1 : 0;
      check("R7 irq", ci_irq, e);
      rd(2'd1, d); check("R7 cir1", d, v);
      rd(2'd0, d); check("R7 status", d, (e << 7) | 8'h08);
      prev1 = 6'(v);
    end

    // R10 hold until read
    frame(6'h09, 6'h3F, 6'h00); frame(6'h09, 6'h3F, 6'h00);
    repeat (5) begin
      @(negedge clk);
      check("R10 hold", ci_irq, 1);
    end
    rd(2'd0, d); check("R10 read", d, 8'h49);
    check("R10 released", ci_irq, 0);

    // R8 enable gate and R11 config readback
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R11 cfg 0", d, 8'h00);
    frame(6'h09, 6'h11, 6'h00);
    check("R8 disabled irq", ci_irq, 0);
    rd(2'd0, d); check("R8 disabled status", d, 8'h09);
    wr(2'd2, 8'h01);
    check("R8 reenable quiet", ci_irq, 0);
    frame(6'h09, 6'h11, 6'h00);
    check("R8 old change lost", ci_irq, 0);
    frame(6'h09, 6'h12, 6'h00);
    check("R8 enabled change", ci_irq, 1);
    rd(2'd0, d); check("R8 status", d, 8'h89);

    // R9 upstream select
    wr(2'd2, 8'h03);
    rd(2'd2, d); check("R11 cfg 3", d, 8'h03);
    frame(6'h09, 6'h12, 6'h2A);
    rd(2'd1, d); check("R9 upstream code", d, 8'h2A);
    check("R9 change irq", ci_irq, 1);
    rd(2'd0, d); check("R9 status", d, 8'h89);
    wr(2'd2, 8'h01);
    frame(6'h09, 6'h12, 6'h2A);
    rd(2'd1, d); check("R9 downstream code", d, 8'h12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule